// File: doc/BRIEF.md
# Pre/Post Trigger Capture Controller

This block runs a two-channel sample store of 1024 entries per channel. The record it leaves behind is always split evenly: 512 samples from before the trigger and 512 from after it. Both channels share one write pointer, one read pointer and one set of status conditions. A single pair of pointers therefore governs the whole store.

After the host releases reset, the block stores every enabled sample until the store is half occupied. From that point the read pointer advances together with the write pointer, 512 entries behind it, and this lasts for as long as no trigger arrives. A trigger can come from a comparator level whose polarity the host selects, or from an active-low software start. The trigger stops the read pointer, and writing goes on until the store is full. Capture then ends and the host steps through the 1024-sample record, oldest sample first, one advance request at a time.

Top module: `cap_ctrl`

## Requirements
- R1: While `rst_n` is low, `phase` reads 0 (reset) and `cap_done` is low. Samples offered during reset are not stored, and reset empties the store. The phase codes are 0 reset, 1 fill, 2 pre-sample, 3 post-sample and 4 retrieve.
- R2: After reset is released, `phase` reads 1 (fill). Every clock edge with `smp_en` high stores `ch0_din` and `ch1_din`. Comparator and software triggers that arrive during fill have no effect.
- R3: `phase` changes to 2 on the clock edge after the edge that stores the 512th sample, whether or not `smp_en` is high on that later edge.
- R4: In pre-sample, the read position advances with every stored sample and stays exactly 512 entries behind the write position. `phase` stays 2 and `cap_done` stays low for as long as no trigger occurs.
- R5: A comparator trigger is a rising edge of `cmp_in` XOR `trig_pol`. It passes through a two-flop synchronizer, so the trigger is accepted on the third rising clock edge after the input changes.
- R6: When `start_n` is low at a clock edge during pre-sample, the trigger is accepted on that same edge.
- R7: Once a trigger is accepted, `phase` reads 3 and stays there. Later comparator or software triggers have no effect.
- R8: After the trigger, the read position holds still while writing continues. `cap_done` goes high, and `phase` reads 4, one edge after the 512th sample stored after the trigger edge. From then on, samples are not stored.
- R9: In retrieve, `ch0_q` and `ch1_q` show the oldest unread entry, and each edge with `host_adv` high moves to the next one. The record holds the 512 samples that end with the sample stored on the trigger edge, followed by the next 512 samples.
- R10: `host_adv` is ignored outside retrieve. A read request is also ignored when the store is empty, and a write is blocked when the store is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Host reset, active low, asynchronous assert |
| smp_en | input | 1 | Sample enable, one sample per high cycle |
| ch0_din | input | 8 | Channel 0 sample |
| ch1_din | input | 8 | Channel 1 sample |
| cmp_in | input | 1 | Asynchronous comparator trigger level |
| trig_pol | input | 1 | Comparator polarity select, 1 inverts |
| start_n | input | 1 | Software trigger, active low |
| host_adv | input | 1 | Host read advance request |
| ch0_q | output | 8 | Channel 0 entry at the read position |
| ch1_q | output | 8 | Channel 1 entry at the read position |
| cap_done | output | 1 | Capture complete |
| phase | output | 3 | Current phase code |

## Verification
Most faults in the pointers or the half latch do not show up until readback. Any slip of the read position during fill, pre-sample or post-sample shifts the retrieved window, so the first entry read after `cap_done` already fails to match. The sample returned must be exactly the 511th one before the trigger sample. A wrong arm or lock state shows up sooner, as a `phase` code that changes one edge early or late around the 512th sample, the trigger edge, or the 512th post-trigger sample.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

  typedef enum logic [2:0] {
    PH_RESET = 3'd0,
    PH_FILL  = 3'd1,
    PH_PRE   = 3'd2,
    PH_POST  = 3'd3,
    PH_RETR  = 3'd4
  } phase_e;

  // Phase decode from the three capture latches; later latches dominate.
  function automatic phase_e phase_of(input logic run, input logic armed,
                                      input logic fired, input logic done);
    if (!run)       return PH_RESET;
    else if (done)  return PH_RETR;
    else if (fired) return PH_POST;
    else if (armed) return PH_PRE;
    else            return PH_FILL;
  endfunction

endpackage

// File: rtl/cap_trig_front.sv
`timescale 1ns/1ps
module cap_trig_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_async,
  input  logic pol,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl;
  logic                   lvl_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= cmp_async;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_async};
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1] ^ pol;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;

  assign rise = lvl & ~lvl_q;

  // R5: an edge pulse lasts a single cycle
  p_rise_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/cap_ptr_ctl.sv
`timescale 1ns/1ps
module cap_ptr_ctl #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          trig_evt,
  input  logic          host_adv,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          done,
  output cap_pkg::phase_e phase
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_C = {1'b1, {AW{1'b0}}};
  localparam logic [PW-1:0] HALF_C  = {2'b01, {(AW-1){1'b0}}};

  function automatic logic [PW-1:0] fill_level(input logic [PW-1:0] w,
                                               input logic [PW-1:0] r);
    return w - r;
  endfunction

  logic [PW-1:0] wp, rp, occ;
  logic armed_q, fired_q, done_q;
  logic full, empty, half_hit;
  logic rd_follow, rd_host, rd_en, fire;

  assign occ      = fill_level(wp, rp);
  assign full     = (occ == DEPTH_C);
  assign empty    = (occ == '0);
  assign half_hit = (occ == HALF_C);

  assign wr_en     = smp_en & ~done_q & ~full;
  assign rd_follow = smp_en & ~fired_q & (armed_q | half_hit) & ~empty;
  assign rd_host   = done_q & host_adv & ~empty;
  assign rd_en     = rd_follow | rd_host;
  assign fire      = armed_q & trig_evt & ~fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (wr_en)    wp      <= wp + 1'b1;
      if (rd_en)    rp      <= rp + 1'b1;
      if (half_hit) armed_q <= 1'b1;
      if (fire)     fired_q <= 1'b1;
      if (full && fired_q) done_q <= 1'b1;
    end
  end

  assign wr_addr = wp[AW-1:0];
  assign rd_addr = rp[AW-1:0];
  assign done    = done_q;
  assign phase   = cap_pkg::phase_of(rst_n, armed_q, fired_q, done_q);

  // R10: occupancy never exceeds the store depth
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_C);
  // R4: while armed and not fired, exactly half the store is held
  p_trail_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !fired_q) |-> (occ == HALF_C));
  // R2: a trigger is only taken once armed
  p_arm_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired_q) |-> $past(armed_q));
  // R7: the trigger latch holds
  p_fire_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fired_q |=> fired_q);
  // R8: read position frozen between trigger and completion
  p_rd_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !done_q) |=> $stable(rp));
  // R8: nothing written once capture is complete
  p_wr_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable(wp));
  // R10: an empty store is not read
  p_empty_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && empty) |=> $stable(rp));
  // R2: read position still during fill below the half mark
  p_fill_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !half_hit) |=> $stable(rp));

endmodule

// File: rtl/cap_store.sv
`timescale 1ns/1ps
module cap_store #(
  parameter int AW  = 10,
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           wa,
  input  logic [AW-1:0]           ra,
  input  logic [NCH-1:0][DW-1:0]  din,
  output logic [NCH-1:0][DW-1:0]  dout
);
  localparam int DEPTH = 1 << AW;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [DW-1:0] mem [0:DEPTH-1];
      always_ff @(posedge clk)
        if (we) mem[wa] <= din[c];
      assign dout[c] = mem[ra];
    end
  endgenerate

endmodule

// File: rtl/cap_ctrl.sv
`timescale 1ns/1ps
module cap_ctrl #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic [DW-1:0] ch0_din,
  input  logic [DW-1:0] ch1_din,
  input  logic          cmp_in,
  input  logic          trig_pol,
  input  logic          start_n,
  input  logic          host_adv,
  output logic [DW-1:0] ch0_q,
  output logic [DW-1:0] ch1_q,
  output logic          cap_done,
  output logic [2:0]    phase
);
  localparam int NCH = 2;

  logic                   cmp_rise;
  logic                   trig_evt;
  logic                   wr_en;
  logic [AW-1:0]          wr_addr, rd_addr;
  logic [NCH-1:0][DW-1:0] din_pk, dout_pk;
  cap_pkg::phase_e        ph;

  cap_trig_front #(.SYNC_STAGES(2)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_async (cmp_in),
    .pol       (trig_pol),
    .rise      (cmp_rise)
  );

  assign trig_evt = cmp_rise | ~start_n;

  cap_ptr_ctl #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .trig_evt (trig_evt),
    .host_adv (host_adv),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .done     (cap_done),
    .phase    (ph)
  );

  assign din_pk = {ch1_din, ch0_din};

  cap_store #(.AW(AW), .DW(DW), .NCH(NCH)) u_store (
    .clk  (clk),
    .we   (wr_en),
    .wa   (wr_addr),
    .ra   (rd_addr),
    .din  (din_pk),
    .dout (dout_pk)
  );

  assign ch0_q = dout_pk[0];
  assign ch1_q = dout_pk[1];
  assign phase = ph;

  // R1: reset phase code while reset is held
  p_reset_phase_r1: assert property (@(posedge clk)
    !rst_n |-> (phase == 3'd0 && !cap_done));

endmodule

// File: tb/sim_cap_ctrl.sv
`timescale 1ns/1ps
module sim_cap_ctrl;
  localparam int HN = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0;
  logic [7:0] ch0_din = '0, ch1_din = '0;
  logic       cmp_in = 1'b0, trig_pol = 1'b0, start_n = 1'b1, host_adv = 1'b0;
  logic [7:0] ch0_q, ch1_q;
  logic       cap_done;
  logic [2:0] phase;

  int total = 0, bad = 0, hn = 0, tidx = 0;
  bit finished = 0;
  logic [7:0] h0 [0:HN-1];
  logic [7:0] h1 [0:HN-1];

  always #10 clk = ~clk;

  cap_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ch0_din(ch0_din),
    .ch1_din(ch1_din), .cmp_in(cmp_in), .trig_pol(trig_pol),
    .start_n(start_n), .host_adv(host_adv), .ch0_q(ch0_q), .ch1_q(ch1_q),
    .cap_done(cap_done), .phase(phase)
  );

  // Expected record position: i-th entry read starts 511 samples before the trigger sample.
  function automatic int rec_index(input int trig_at, input int i);
    return trig_at - 511 + i;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one sample cycle at a falling edge; record it if enabled.
  task automatic step(input bit en);
    logic [7:0] d0, d1;
    d0 = 8'($urandom);
    d1 = 8'($urandom);
    smp_en  = en;
    ch0_din = d0;
    ch1_din = d1;
    @(negedge clk);
    if (en && hn < HN) begin
      h0[hn] = d0;
      h1[hn] = d1;
      hn++;
    end
  endtask

  task automatic run(input int mode, input bit pol);
    bit ok;
    rst_n = 1'b0; trig_pol = pol; cmp_in = pol; start_n = 1'b1;
    host_adv = 1'b0; smp_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", phase, 0);
    chk("R1 done in reset", cap_done, 0);
    smp_en = 1'b0;
    rst_n = 1'b1;
    hn = 0;
    @(negedge clk);
    chk("R2 fill phase", phase, 1);
    // fill with early lockout triggers and ignored host advances
    for (int k = 0; hn < 512; k++) begin
      start_n  = !(k >= 2 && k <= 4);
      cmp_in   = (k >= 6 && k <= 8) ? ~pol : pol;
      host_adv = 1'($urandom % 2);
      step(($urandom % 4) != 0);
      if (k == 15) chk("R2 trigger ignored in fill", phase, 1);
    end
    start_n = 1'b1; cmp_in = pol; host_adv = 1'b0;
    chk("R3 still fill after 512th", phase, 1);
    step(1'b0);
    chk("R3 pre-sample after half", phase, 2);
    ok = 1;
    for (int k = 0; k < 1500; k++) begin
      host_adv = 1'($urandom % 2);
      step(($urandom % 3) != 0);
      if (phase != 3'd2 || cap_done) ok = 0;
    end
    host_adv = 1'b0;
    chk("R4 pre-sample holds", ok, 1);
    if (mode == 0) begin
      start_n = 1'b0;
      step(1'b1);
      start_n = 1'b1;
      tidx = hn - 1;
      chk("R6 software start", phase, 3);
    end else begin
      cmp_in = ~pol;
      step(1'b1);
      step(1'b1);
      chk("R5 not yet fired", phase, 2);
      step(1'b1);
      tidx = hn - 1;
      chk("R5 comparator fired", phase, 3);
    end
    for (int k = 0; k < 512; k++) begin
      start_n = (k % 7) != 3;
      cmp_in  = ((k % 11) < 5) ? ~pol : pol;
      step(1'b1);
    end
    chk("R7 retrigger ignored", phase, 3);
    chk("R8 not done before last", cap_done, 0);
    start_n = 1'b1; cmp_in = pol;
    step(1'b0);
    chk("R8 done after 512 post", cap_done, 1);
    chk("R8 retrieve phase", phase, 4);
    for (int i = 0; i < 1024; i++) begin
      smp_en  = 1'($urandom % 2);
      ch0_din = 8'($urandom);
      ch1_din = 8'($urandom);
      chk("R9 ch0 record", ch0_q, h0[rec_index(tidx, i)]);
      chk("R9 ch1 record", ch1_q, h1[rec_index(tidx, i)]);
      host_adv = 1'b1;
      @(negedge clk);
      host_adv = 1'b0;
    end
    smp_en = 1'b0;
    chk("R9 stays retrieve", phase, 4);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    run(0, 1'b0);   // software start
    run(1, 1'b0);   // comparator, normal polarity
    run(1, 1'b1);   // comparator, inverted polarity
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule